// File: doc/BRIEF.md
# Latched Program Counter Unit

This block holds the byte-addressed program counter of an 8-bit core whose instructions are 16 or 32 bits long. The counter is 21 bits wide by default (a 2 MB code space), and its least significant bit is always zero because every instruction starts at an even byte address. After each fetch, the fetch stage pulses an advance strobe, and a size flag selects a step of 2 or 4. Branches and calls load a byte-address target, and the unit clears the low bit of that target.

Software sees the counter through three byte-wide registers: a low byte, a high byte latch and an upper byte latch. A read of the low byte returns the live PC[7:0]. In the same cycle it captures PC[15:8] and PC[20:16] into the two latches, so a later read of those latches gives a value that matches the low byte already read. A write to the low byte performs a computed jump: the new counter is made from the two latches and the written byte, with bit 0 cleared. Software can also write the latches directly to prepare such a jump. Those writes leave the running counter untouched until the low byte is written.

Top module: `pc_latch_unit`

## Requirements
- R1: While rst_ni is low, pc_o and both latches clear to 0. Reads of select codes 1 and 2 then return 0.
- R2: Bit 0 of pc_o is 0 in every cycle.
- R3: With adv_i high and no higher-priority event, pc_o increases on the next clock by 4 if adv_dbl_i is 1 and by 2 otherwise. The sum wraps modulo 2^PC_W.
- R4: Register select code 0 is the low byte. A read returns pc_o[7:0] combinationally. When reg_rd_i is also high, the clock edge copies pc_o[15:8] into the high latch and pc_o[20:16] into the upper latch.
- R5: A write with select code 0 makes pc_o equal to {upper latch, high latch, reg_wdata_i[7:1], 0} on the next clock.
- R6: With load_i high and no low-byte write, pc_o becomes load_addr_i with bit 0 cleared on the next clock.
- R7: Select code 1 reads and writes the high latch. Select code 2 reads the upper latch zero-extended to 8 bits, and a write stores reg_wdata_i[4:0] into it. Neither write changes pc_o.
- R8: A low-byte write has priority over load_i, and load_i has priority over adv_i, in the same cycle.
- R9: Select code 3 reads 0, and writes to it change neither pc_o nor the latches.
- R10: With no advance, no load and no low-byte write, pc_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance after fetch |
| adv_dbl_i | input | 1 | 1: double-word step of 4, 0: step of 2 |
| load_i | input | 1 | Branch or call load strobe |
| load_addr_i | input | PC_W | Byte-address target |
| reg_sel_i | input | 2 | 0 low, 1 high latch, 2 upper latch, 3 none |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current select |
| pc_o | output | PC_W | Program counter |

## Verification
The checker assumes that a read strobe and a write strobe never occur in the same cycle. The snapshot and latch-write properties therefore leave such cycles out of their antecedents. The bench enforces this: the random stimulus picks either a read, a write or neither in each cycle. Every other input combination is allowed, including a low-byte write together with a load and an advance, so the priority ordering is exercised against the reference model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_NONE  = 2'd3
  } pcu_sel_e;
endpackage

// File: rtl/pcu_latch.sv
module pcu_latch #(
  parameter int HI_W = 8,
  parameter int UP_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            snap_i,
  input  logic [HI_W-1:0] pc_hi_i,
  input  logic [UP_W-1:0] pc_up_i,
  input  logic            wr_hi_i,
  input  logic            wr_up_i,
  input  logic [HI_W-1:0] wr_hi_data_i,
  input  logic [UP_W-1:0] wr_up_data_i,
  output logic [HI_W-1:0] hi_o,
  output logic [UP_W-1:0] up_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      up_o <= '0;
    end else if (snap_i) begin
      hi_o <= pc_hi_i;
      up_o <= pc_up_i;
    end else begin
      if (wr_hi_i) hi_o <= wr_hi_data_i;
      if (wr_up_i) up_o <= wr_up_data_i;
    end
  end
endmodule

// File: rtl/pcu_next.sv
module pcu_next #(
  parameter int WORD_W = 20,
  parameter int HI_W   = 8,
  parameter int UP_W   = 5
) (
  input  logic [WORD_W-1:0] pc_q_i,
  input  logic              adv_i,
  input  logic              adv_dbl_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              wr_low_i,
  input  logic [6:0]        low_word_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [UP_W-1:0]   up_i,
  output logic [WORD_W-1:0] pc_d_o,
  output logic              pc_en_o
);
  // counter is kept in instruction words; bit 0 of the byte address is implicit
  logic [WORD_W-1:0] step;
  assign step = adv_dbl_i ? WORD_W'(2) : WORD_W'(1);

  always_comb begin
    pc_d_o  = pc_q_i;
    pc_en_o = 1'b1;
    if (wr_low_i)    pc_d_o = {up_i, hi_i, low_word_i};
    else if (load_i) pc_d_o = load_word_i;
    else if (adv_i)  pc_d_o = pc_q_i + step;
    else             pc_en_o = 1'b0;
  end
endmodule

// File: rtl/pcu_rdmux.sv
module pcu_rdmux #(
  parameter int UP_W = 5
) (
  input  logic [1:0]      sel_i,
  input  logic [7:0]      pc_lo_i,
  input  logic [7:0]      hi_i,
  input  logic [UP_W-1:0] up_i,
  output logic [7:0]      rdata_o
);
  import pcu_pkg::*;
  always_comb begin
    unique case (pcu_sel_e'(sel_i))
      SEL_LOW:   rdata_o = pc_lo_i;
      SEL_HIGH:  rdata_o = hi_i;
      SEL_UPPER: rdata_o = 8'(up_i);
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pc_latch_unit.sv
module pc_latch_unit #(
  parameter int PC_W = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            adv_dbl_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_addr_i,
  input  logic [1:0]      reg_sel_i,
  input  logic            reg_rd_i,
  input  logic            reg_wr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic [PC_W-1:0] pc_o
);
  import pcu_pkg::*;
  localparam int WORD_W = PC_W - 1;
  localparam int HI_W   = 8;
  localparam int UP_W   = PC_W - 16;

  logic [WORD_W-1:0] pc_q, pc_d;
  logic              pc_en;
  logic [HI_W-1:0]   hi_q;
  logic [UP_W-1:0]   up_q;
  logic              sel_low, sel_hi, sel_up;
  logic              unused_bit0;

  assign unused_bit0 = load_addr_i[0];
  assign sel_low = pcu_sel_e'(reg_sel_i) == SEL_LOW;
  assign sel_hi  = pcu_sel_e'(reg_sel_i) == SEL_HIGH;
  assign sel_up  = pcu_sel_e'(reg_sel_i) == SEL_UPPER;
  assign pc_o    = {pc_q, 1'b0};

  pcu_latch #(.HI_W(HI_W), .UP_W(UP_W)) i_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snap_i      (reg_rd_i && sel_low),
    .pc_hi_i     (pc_o[15:8]),
    .pc_up_i     (pc_o[PC_W-1:16]),
    .wr_hi_i     (reg_wr_i && sel_hi),
    .wr_up_i     (reg_wr_i && sel_up),
    .wr_hi_data_i(reg_wdata_i),
    .wr_up_data_i(reg_wdata_i[UP_W-1:0]),
    .hi_o        (hi_q),
    .up_o        (up_q)
  );

  pcu_next #(.WORD_W(WORD_W), .HI_W(HI_W), .UP_W(UP_W)) i_next (
    .pc_q_i     (pc_q),
    .adv_i      (adv_i),
    .adv_dbl_i  (adv_dbl_i),
    .load_i     (load_i),
    .load_word_i(load_addr_i[PC_W-1:1]),
    .wr_low_i   (reg_wr_i && sel_low),
    .low_word_i (reg_wdata_i[7:1]),
    .hi_i       (hi_q),
    .up_i       (up_q),
    .pc_d_o     (pc_d),
    .pc_en_o    (pc_en)
  );

  pcu_rdmux #(.UP_W(UP_W)) i_rdmux (
    .sel_i  (reg_sel_i),
    .pc_lo_i(pc_o[7:0]),
    .hi_i   (hi_q),
    .up_i   (up_q),
    .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int PC_W = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adv_i,
  input logic            adv_dbl_i,
  input logic            load_i,
  input logic [PC_W-1:0] load_addr_i,
  input logic [1:0]      reg_sel_i,
  input logic            reg_rd_i,
  input logic            reg_wr_i,
  input logic [7:0]      reg_wdata_i,
  input logic [PC_W-1:0] pc_o,
  input logic [7:0]      hi_q,
  input logic [PC_W-17:0] up_q
);
  logic wr_low;
  assign wr_low = reg_wr_i && reg_sel_i == 2'd0;

  // R3: sequential advance
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !wr_low) |=>
      pc_o == PC_W'($past(pc_o) + ($past(adv_dbl_i) ? 3'd4 : 3'd2)));

  // R5, R8: computed jump from latches wins over everything
  a_r5_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_low |=> pc_o == {$past(up_q), $past(hi_q), $past(reg_wdata_i[7:1]), 1'b0});

  // R6, R8: load wins over advance
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_low) |=> pc_o == {$past(load_addr_i[PC_W-1:1]), 1'b0});

  // R4: snapshot of upper bytes
  a_r4_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_wr_i && reg_sel_i == 2'd0) |=>
      (hi_q == $past(pc_o[15:8]) && up_q == $past(pc_o[PC_W-1:16])));

  // R7: latch writes leave the counter alone
  a_r7_latch_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_rd_i && reg_sel_i == 2'd1 && !adv_i && !load_i) |=>
      ($stable(pc_o) && hi_q == $past(reg_wdata_i)));

  // R9: unused select changes nothing
  a_r9_none_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_rd_i || reg_wr_i) && reg_sel_i == 2'd3) |=> ($stable(hi_q) && $stable(up_q)));

  // R10: idle hold
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i && !wr_low) |=> $stable(pc_o));
endmodule

bind pc_latch_unit pcu_checker #(.PC_W(PC_W)) i_pcu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adv_i      (adv_i),
  .adv_dbl_i  (adv_dbl_i),
  .load_i     (load_i),
  .load_addr_i(load_addr_i),
  .reg_sel_i  (reg_sel_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .pc_o       (pc_o),
  .hi_q       (hi_q),
  .up_q       (up_q)
);

// File: tb/test_pc_latch_unit.sv
module test_pc_latch_unit;
  localparam int PC_W = 21;
  localparam int MASK = (1 << PC_W) - 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            adv_i = 0, adv_dbl_i = 0, load_i = 0, reg_rd_i = 0, reg_wr_i = 0;
  logic [PC_W-1:0] load_addr_i = '0;
  logic [1:0]      reg_sel_i = 2'd3;
  logic [7:0]      reg_wdata_i = '0;
  logic [7:0]      reg_rdata_o;
  logic [PC_W-1:0] pc_o;

  int n_vec = 0, n_err = 0;
  int m_pc = 0, m_hi = 0, m_up = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pc_latch_unit #(.PC_W(PC_W)) i_pc_latch_unit (.*);

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for();
    if (reg_wr_i && reg_sel_i == 2'd0) return "R5/R8";
    if (load_i) return "R6/R8";
    if (adv_i) return "R3";
    return "R10";
  endfunction

  // drive one cycle: inputs set after negedge, rdata checked, then edge, then pc checked
  task automatic cyc(bit adv, bit dbl, bit ld, int addr, int sel, bit rd, bit wr, int wd);
    int exp_rd;
    string t;
    adv_i = adv; adv_dbl_i = dbl; load_i = ld; load_addr_i = addr[PC_W-1:0];
    reg_sel_i = sel[1:0]; reg_rd_i = rd; reg_wr_i = wr; reg_wdata_i = wd[7:0];
    #1;
    case (sel)
      0: exp_rd = m_pc & 255;
      1: exp_rd = m_hi;
      2: exp_rd = m_up;
      default: exp_rd = 0;
    endcase
    check(sel == 0 ? "R4" : (sel == 3 ? "R9" : "R7"), int'(reg_rdata_o), exp_rd);
    t = tag_for();
    // reference model update
    begin
      int old = m_pc;
      if (wr && sel == 0) m_pc = (m_up << 16) | (m_hi << 8) | (wd & 8'hFE);
      else if (ld) m_pc = addr & (MASK - 1);
      else if (adv) m_pc = (m_pc + (dbl ? 4 : 2)) & MASK;
      if (rd && sel == 0) begin m_hi = (old >> 8) & 255; m_up = (old >> 16) & 31; end
      if (wr && sel == 1) m_hi = wd & 255;
      if (wr && sel == 2) m_up = wd & 31;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check(t, int'(pc_o), m_pc);
    check("R2", int'(pc_o[0]), 0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", int'(pc_o), 0);
    reg_sel_i = 2'd1; #1 check("R1", int'(reg_rdata_o), 0);
    reg_sel_i = 2'd2; #1 check("R1", int'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3: single and double steps
    cyc(1, 0, 0, 0, 3, 0, 0, 0);
    cyc(1, 1, 0, 0, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 3, 0, 0, 0);              // R10
    // R6: odd target gets bit 0 cleared
    cyc(1, 0, 1, 21'h1ABCD5, 3, 0, 0, 0);
    // R4: snapshot, then read latches
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 2, 1, 0, 0);
    // R7: write latches, pc unchanged
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h34);
    cyc(0, 0, 0, 0, 2, 0, 1, 8'hF2);
    cyc(0, 0, 0, 0, 2, 0, 0, 0);
    // R5 + R8: low write with load and advance pending, odd data
    cyc(1, 1, 1, 21'h000100, 0, 0, 1, 8'h57);
    // R9: select 3 write ignored
    cyc(0, 0, 0, 0, 3, 0, 1, 8'hFF);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    // R3 wrap at top of space
    cyc(0, 0, 1, 21'h1FFFFE, 3, 0, 0, 0);
    cyc(1, 1, 0, 0, 3, 0, 0, 0);
    cyc(0, 0, 1, 21'h1FFFFE, 3, 0, 0, 0);
    cyc(1, 0, 0, 0, 3, 0, 0, 0);
    // random mix; read and write never together
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 2);
      cyc($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 7) == 0),
          int'($urandom) & MASK, $urandom_range(0, 3), op == 1, op == 2, $urandom_range(0, 255));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule